// File: doc/BRIEF.md
# I2C Master Receive Interlock and Interrupt Registers

This block is the register side of a byte-level I2C master. It holds four registers behind a simple single-cycle write/read port: a command register, an interrupt status register cleared by writing ones, an interrupt enable register and a receive byte buffer. It asks a separate byte-level bus engine to receive one byte at a time and drives a single level interrupt line toward the interrupt controller.

Its main job is flow control on receptions. The receive-done status bit works as an interlock. While it is set, a pending receive command stays in the command register and no new byte is requested. As soon as software clears the bit, the pending command runs without a further write. Each request to the engine is a valid/ready transfer. `rx_req_valid` and `rx_req_nack` stay stable until `rx_req_ready` is seen high on a clock edge. The reply is a valid/ready transfer as well. `rx_rsp_ready` is high only while one reply is outstanding, so the engine must hold `rx_rsp_valid` and its data until that point.

Register map (word addresses): 0 command, 1 status, 2 enable, 3 byte buffer. Reads have no side effects.

Top module: `i2cm_rx_regs`

## Requirements
- R1: After reset every register reads zero, the state field reads 0 (idle), and `irq`, `rx_req_valid` and `rx_rsp_ready` are low.
- R2: The enable register keeps only write bits [14:0]. A status write clears the status bits whose write bits [14:0] are one. Write bit 15 touches neither register, and read bits [31:15] of both are zero.
- R3: A command write loads bits [15:0] into command bits [15:0] and leaves the state field (bits [19:16]) alone. It clears every status bit except receive-done (bit 2), which keeps its value.
- R4: With receive-done clear, a command holding receive (bit 3) or receive-last (bit 4) raises `rx_req_valid` in the cycle after the write. `rx_req_nack` is 1 exactly when receive-last is set. While the request or its reply is outstanding, the state field reads 2 (receiving). After the reply it reads 1 (active).
- R5: Once raised, `rx_req_valid` and `rx_req_nack` hold steady until accepted with `rx_req_ready`.
- R6: A reply with `rx_rsp_err` low stores the byte in buffer bits [15:8], sets receive-done and clears command bits 3 and 4.
- R7: A reply with `rx_rsp_err` high stores 0xFF in buffer bits [15:8], leaves receive-done clear and clears command bits 3 and 4.
- R8: While receive-done is set, no request is raised and a receive command stays readable in the command register.
- R9: When a status write takes receive-done from 1 to 0 while a receive command is pending, `rx_req_valid` rises in the next cycle.
- R10: `irq` goes high when status AND enable is non-zero. It stays high until a status write leaves every status bit zero, even if the remaining set bits are disabled.
- R11: If `stat_set` raises a bit in the same cycle that a status write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| stat_set | input | 15 | One-cycle status event pulses from the bus engine |
| rx_req_valid | output | 1 | Byte receive request valid |
| rx_req_ready | input | 1 | Engine accepts the request |
| rx_req_nack | output | 1 | NACK the byte after receiving it |
| rx_rsp_valid | input | 1 | Received byte reply valid |
| rx_rsp_ready | output | 1 | Block waits for a reply |
| rx_rsp_data | input | 8 | Received byte |
| rx_rsp_err | input | 1 | Reception failed |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: 15 status bits with receive-done at bit 2, a 16-bit command field and 8-bit bytes. At that size every status bit can be set, cleared and enabled at random within a short run. This covers same-cycle set/clear collisions, partial clears that leave only disabled bits set, and full clears that drop the line. Receptions are directed. They cover a request held without ready over several cycles, success and error replies, a receive-last command stalled behind receive-done, and the start that follows on its own when receive-done is cleared.

// File: rtl/i2cm_rx_pkg.sv
package i2cm_rx_pkg;
  localparam int STATE_W = 4;
  localparam logic [STATE_W-1:0] LST_IDLE   = 4'd0;
  localparam logic [STATE_W-1:0] LST_ACTIVE = 4'd1;
  localparam logic [STATE_W-1:0] LST_RXD    = 4'd2;

  localparam int ADR_CMD = 0;
  localparam int ADR_STS = 1;
  localparam int ADR_EN  = 2;
  localparam int ADR_BUF = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/i2cm_rx_seq.sv
module i2cm_rx_seq
  import i2cm_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_ok,
  input  logic              last_i,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_nack,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [BYTE_W-1:0] rsp_data,
  input  logic              rsp_err,
  output logic              done_o,
  output logic              done_ok_o,
  output logic [BYTE_W-1:0] done_data_o,
  output logic              busy_o
);
  seq_state_e st_q;
  logic       nack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      nack_q <= 1'b0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (launch_ok) begin
          st_q   <= SEQ_REQ;
          nack_q <= last_i;
        end
        SEQ_REQ:  if (req_ready) st_q <= SEQ_WAIT;
        SEQ_WAIT: if (rsp_valid) st_q <= SEQ_IDLE;
        default:  st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign req_valid   = (st_q == SEQ_REQ);
  assign req_nack    = nack_q;
  assign rsp_ready   = (st_q == SEQ_WAIT);
  assign busy_o      = (st_q != SEQ_IDLE);
  assign done_o      = rsp_ready && rsp_valid;
  assign done_ok_o   = !rsp_err;
  assign done_data_o = rsp_err ? {BYTE_W{1'b1}} : rsp_data;
endmodule

// File: rtl/i2cm_irq_stat.sv
module i2cm_irq_stat #(
  parameter int STAT_W     = 15,
  parameter int RXDONE_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic [STAT_W-1:0] hw_set,
  input  logic [STAT_W-1:0] en_next,
  output logic [STAT_W-1:0] sts_q,
  output logic              irq_q
);
  localparam logic [STAT_W-1:0] KEEP_ON_CMD = STAT_W'(1) << RXDONE_BIT;

  logic [STAT_W-1:0] sts_d;
  logic              irq_d;

  always_comb begin
    sts_d = sts_q;
    if (cmd_wr) sts_d = sts_d & KEEP_ON_CMD;
    if (clr_wr) sts_d = sts_d & ~clr_mask;
    sts_d = sts_d | hw_set;
    if (clr_wr && (sts_d == '0)) irq_d = 1'b0;
    else                         irq_d = irq_q | (|(sts_d & en_next));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/i2cm_rx_regs.sv
module i2cm_rx_regs
  import i2cm_rx_pkg::*;
#(
  parameter int WR_W       = 16,
  parameter int RD_W       = 32,
  parameter int BYTE_W     = 8,
  parameter int STAT_W     = 15,
  parameter int ADDR_W     = 2,
  parameter int RXDONE_BIT = 2,
  parameter int RX_BIT     = 3,
  parameter int RXLAST_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WR_W-1:0]   reg_wdata,
  output logic [RD_W-1:0]   reg_rdata,
  input  logic [STAT_W-1:0] stat_set,
  output logic              rx_req_valid,
  input  logic              rx_req_ready,
  output logic              rx_req_nack,
  input  logic              rx_rsp_valid,
  output logic              rx_rsp_ready,
  input  logic [BYTE_W-1:0] rx_rsp_data,
  input  logic              rx_rsp_err,
  output logic              irq
);
  localparam int STATE_LSB = WR_W;
  localparam int BUF_LSB   = BYTE_W;

  logic              cmd_wr, clr_wr, en_wr;
  logic [WR_W-1:0]   cmd_q;
  logic [STAT_W-1:0] en_q, en_next, sts_q, hw_set;
  logic [BYTE_W-1:0] buf_q, done_data;
  logic              act_q, done, done_ok, busy, launch_ok;
  logic [STATE_W-1:0] state_fld;

  assign cmd_wr  = reg_wr && (reg_addr == ADDR_W'(ADR_CMD));
  assign clr_wr  = reg_wr && (reg_addr == ADDR_W'(ADR_STS));
  assign en_wr   = reg_wr && (reg_addr == ADDR_W'(ADR_EN));
  assign en_next = en_wr ? reg_wdata[STAT_W-1:0] : en_q;

  assign launch_ok = (cmd_q[RX_BIT] | cmd_q[RXLAST_BIT]) & ~sts_q[RXDONE_BIT];

  i2cm_rx_seq #(.BYTE_W(BYTE_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_ok  (launch_ok),
    .last_i     (cmd_q[RXLAST_BIT]),
    .req_valid  (rx_req_valid),
    .req_ready  (rx_req_ready),
    .req_nack   (rx_req_nack),
    .rsp_valid  (rx_rsp_valid),
    .rsp_ready  (rx_rsp_ready),
    .rsp_data   (rx_rsp_data),
    .rsp_err    (rx_rsp_err),
    .done_o     (done),
    .done_ok_o  (done_ok),
    .done_data_o(done_data),
    .busy_o     (busy)
  );

  always_comb begin
    hw_set = stat_set;
    if (done && done_ok) hw_set[RXDONE_BIT] = 1'b1;
  end

  i2cm_irq_stat #(.STAT_W(STAT_W), .RXDONE_BIT(RXDONE_BIT)) stat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (cmd_wr),
    .clr_wr  (clr_wr),
    .clr_mask(reg_wdata[STAT_W-1:0]),
    .hw_set  (hw_set),
    .en_next (en_next),
    .sts_q   (sts_q),
    .irq_q   (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      en_q  <= '0;
      buf_q <= '0;
      act_q <= 1'b0;
    end else begin
      logic [WR_W-1:0] cmd_d;
      cmd_d = cmd_wr ? reg_wdata : cmd_q;
      if (done) begin
        cmd_d[RX_BIT]     = 1'b0;
        cmd_d[RXLAST_BIT] = 1'b0;
        buf_q <= done_data;
        act_q <= 1'b1;
      end
      cmd_q <= cmd_d;
      en_q  <= en_next;
    end
  end

  assign state_fld = busy ? LST_RXD : (act_q ? LST_ACTIVE : LST_IDLE);

  always_comb begin
    reg_rdata = '0;
    unique case (int'(reg_addr))
      ADR_CMD: begin
        reg_rdata[WR_W-1:0]              = cmd_q;
        reg_rdata[STATE_LSB +: STATE_W]  = state_fld;
      end
      ADR_STS: reg_rdata[STAT_W-1:0]      = sts_q;
      ADR_EN:  reg_rdata[STAT_W-1:0]      = en_q;
      default: reg_rdata[BUF_LSB +: BYTE_W] = buf_q;
    endcase
  end
endmodule

// File: rtl/i2cm_rx_regs_chk.sv
module i2cm_rx_regs_chk
  import i2cm_rx_pkg::*;
#(
  parameter int STAT_W     = 15,
  parameter int ADDR_W     = 2,
  parameter int RXDONE_BIT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               rx_req_valid,
  input logic               rx_req_ready,
  input logic               rx_req_nack,
  input logic               rx_rsp_valid,
  input logic               rx_rsp_ready,
  input logic               rx_rsp_err,
  input logic               irq,
  input logic [STAT_W-1:0]  sts,
  input logic [STATE_W-1:0] state_fld
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req_valid && !rx_req_ready |=> rx_req_valid && $stable(rx_req_nack));

  // R4
  rxd_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req_valid || rx_rsp_ready) |-> state_fld == LST_RXD);

  // R8
  interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts[RXDONE_BIT] && !rx_req_valid |=> !rx_req_valid);

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rsp_valid && rx_rsp_ready && !rx_rsp_err |=> sts[RXDONE_BIT]);

  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr && (reg_addr == ADDR_W'(ADR_STS))) && (sts == '0));
endmodule

bind i2cm_rx_regs i2cm_rx_regs_chk #(
  .STAT_W(STAT_W), .ADDR_W(ADDR_W), .RXDONE_BIT(RXDONE_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .rx_req_valid(rx_req_valid), .rx_req_ready(rx_req_ready),
  .rx_req_nack(rx_req_nack), .rx_rsp_valid(rx_rsp_valid),
  .rx_rsp_ready(rx_rsp_ready), .rx_rsp_err(rx_rsp_err), .irq(irq),
  .sts(sts_q), .state_fld(state_fld)
);

// File: tb/i2cm_rx_regs_tb.sv
module i2cm_rx_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [14:0] stat_set = '0;
  logic        rx_req_valid, rx_req_nack, rx_rsp_ready, irq;
  logic        rx_req_ready = 1'b0;
  logic        rx_rsp_valid = 1'b0;
  logic [7:0]  rx_rsp_data = '0;
  logic        rx_rsp_err = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  i2cm_rx_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_set(stat_set),
    .rx_req_valid(rx_req_valid), .rx_req_ready(rx_req_ready),
    .rx_req_nack(rx_req_nack), .rx_rsp_valid(rx_rsp_valid),
    .rx_rsp_ready(rx_rsp_ready), .rx_rsp_data(rx_rsp_data),
    .rx_rsp_err(rx_rsp_err), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  function automatic logic [14:0] sts_model(input logic [14:0] s, input bit clr,
                                            input logic [14:0] m, input logic [14:0] set);
    return (clr ? (s & ~m) : s) | set;
  endfunction

  function automatic bit irq_model(input bit cur, input bit clr, input logic [14:0] s,
                                   input logic [14:0] en);
    if (clr && s == '0) return 1'b0;
    return cur | (|(s & en));
  endfunction

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 2'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic serve(input int hold, input logic [7:0] d, input bit err,
                       input bit exp_nack, input string tag);
    logic [31:0] v;
    chk_eq({tag, " req valid"}, {31'd0, rx_req_valid}, 32'd1);
    chk_eq("R4 nack", {31'd0, rx_req_nack}, {31'd0, exp_nack});
    rd(0, v);
    chk_eq("R4 state rxd", v[19:16], 32'd2);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk_eq("R5 valid held", {30'd0, rx_req_valid, rx_req_nack}, {30'd0, 1'b1, exp_nack});
    end
    rx_req_ready = 1'b1;
    @(negedge clk);
    rx_req_ready = 1'b0;
    chk_eq("R4 waiting", {30'd0, rx_req_valid, rx_rsp_ready}, 32'd1);
    rx_rsp_valid = 1'b1; rx_rsp_data = d; rx_rsp_err = err;
    @(negedge clk);
    rx_rsp_valid = 1'b0; rx_rsp_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [14:0] s_m, en_m;
    bit irq_m;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a, v); chk_eq("R1 reg zero", v, 32'd0); end
    chk_eq("R1 outputs", {29'd0, irq, rx_req_valid, rx_rsp_ready}, 32'd0);

    // R2 enable width
    wr(2, 16'hFFFF); rd(2, v); chk_eq("R2 enable 15 bits", v, 32'h7FFF);
    wr(2, 16'h0000);

    // R11 same-cycle set and clear
    stat_set = 15'h0020; reg_wr = 1'b1; reg_addr = 2'(1); reg_wdata = 16'hFFFF;
    @(negedge clk); reg_wr = 1'b0; stat_set = '0;
    rd(1, v); chk_eq("R11 set wins", v, 32'h0020);
    wr(1, 16'h8000); rd(1, v); chk_eq("R2 bit15 no clear", v, 32'h0020);
    wr(1, 16'h0020); rd(1, v); chk_eq("R2 w1c", v, 32'd0);

    // R10 partial clear keeps line high
    wr(2, 16'h0001);
    stat_set = 15'h0003; @(negedge clk); stat_set = '0;
    chk_eq("R10 irq raised", {31'd0, irq}, 32'd1);
    wr(1, 16'h0001); rd(1, v);
    chk_eq("R10 partial status", v, 32'h0002);
    chk_eq("R10 irq held", {31'd0, irq}, 32'd1);
    wr(1, 16'h0002); chk_eq("R10 irq dropped", {31'd0, irq}, 32'd0);

    // R2 R10 R11 random status traffic against the model
    s_m = '0; en_m = 15'h0001; irq_m = 1'b0;
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [15:0] w;
      logic [14:0] set;
      op  = $urandom_range(0, 2);
      w   = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
      set = ($urandom_range(0, 1) == 0) ? 15'($urandom) & 15'($urandom) : 15'd0;
      stat_set = set;
      if (op < 2) begin reg_wr = 1'b1; reg_addr = (op == 0) ? 2'd1 : 2'd2; reg_wdata = w; end
      @(negedge clk);
      reg_wr = 1'b0; stat_set = '0;
      if (op == 1) en_m = w[14:0];
      s_m   = sts_model(s_m, op == 0, w[14:0], set);
      irq_m = irq_model(irq_m, op == 0, s_m, en_m);
      rd(1, v); chk_eq("R11 random status", v, {17'd0, s_m});
      chk_eq("R10 random irq", {31'd0, irq}, {31'd0, irq_m});
    end
    wr(1, 16'hFFFF); wr(2, 16'h0000);
    chk_eq("R10 cleanup irq", {31'd0, irq}, 32'd0);

    // R3 command write
    stat_set = 15'h7FFF; @(negedge clk); stat_set = '0;
    wr(0, 16'h1207); rd(0, v); chk_eq("R3 cmd low bits", v, 32'h0000_1207);
    rd(1, v); chk_eq("R3 status kept rxdone only", v, 32'h0004);
    wr(1, 16'hFFFF); wr(0, 16'h0000);

    // R4 R5 R6 successful receive
    wr(2, 16'h0004);
    wr(0, 16'h0008);
    chk_eq("R4 no req same cycle", {31'd0, rx_req_valid}, 32'd0);
    @(negedge clk);
    serve(3, 8'h5A, 1'b0, 1'b0, "R4");
    rd(3, v); chk_eq("R6 buffer", v, 32'h0000_5A00);
    rd(1, v); chk_eq("R6 rxdone set", v, 32'h0004);
    rd(0, v); chk_eq("R6 cmd cleared, state active", v, 32'h0001_0000);
    chk_eq("R10 irq on rxdone", {31'd0, irq}, 32'd1);

    // R8 stall while rxdone set
    wr(0, 16'h0010);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_eq("R8 no request", {31'd0, rx_req_valid}, 32'd0);
    end
    rd(0, v); chk_eq("R8 cmd pending", v, 32'h0001_0010);

    // R9 clear releases pending receive-last; R7 error reply
    wr(1, 16'h0004);
    rd(1, v); chk_eq("R9 status zero", v, 32'd0);
    chk_eq("R10 full clear drops irq", {31'd0, irq}, 32'd0);
    chk_eq("R9 not yet", {31'd0, rx_req_valid}, 32'd0);
    @(negedge clk);
    serve(0, 8'h33, 1'b1, 1'b1, "R9");
    rd(3, v); chk_eq("R7 buffer 0xFF", v, 32'h0000_FF00);
    rd(1, v); chk_eq("R7 rxdone clear", v, 32'd0);
    rd(0, v); chk_eq("R7 cmd cleared", v, 32'h0001_0000);
    chk_eq("R7 irq low", {31'd0, irq}, 32'd0);

    // R3 command write keeps rxdone
    wr(0, 16'h0008); @(negedge clk);
    serve(1, 8'hC3, 1'b0, 1'b0, "R6");
    stat_set = 15'h4100; @(negedge clk); stat_set = '0;
    wr(0, 16'h0000); rd(1, v); chk_eq("R3 rxdone kept", v, 32'h0004);
    rd(3, v); chk_eq("R6 second byte", v, 32'h0000_C300);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule